// File: doc/BRIEF.md
# Bunch Phase and Intensity Extractor

This block turns a filtered beam-pickup waveform, digitised at exactly four samples per bunch period, into two signed per-bunch measurements. A strobe marks the first sample of each bunch window. The block takes that sample and the four that follow, which straddle the bunch centre with the peak at the middle one, and applies two fixed difference formulas. One formula is the second sample minus the fourth. The other is the middle sample minus the floored mean of the two outer samples. Windows of adjacent bunches share one sample, because the last sample of one bunch is the first of the next.

A pickup-type select assigns the formulas to the outputs. A unipolar wall-current pulse gives the phase from the second-minus-fourth difference and the intensity from the centre-minus-mean term. A bipolar stripline doublet reverses these two roles.

Every phase result is also added into a batch accumulator. After a programmable number of bunches, the block emits the batch average for a slow feedback loop, for example over 84 bunches.

Top module: `bunch_meas`

## Requirements
- R1: While reset is low, and after it is released until the first result, `meas_vld_o` and `avg_vld_o` are 0 and `phase_o`, `amp_o` and `avg_o` are 0.
- R2: If `bnd_i` is 1 in the cycle carrying sample A, the samples of the next four cycles are B, C, D and E. The results appear with `meas_vld_o` high for exactly one cycle, in the cycle after the one carrying E. Strobes may come every 4 cycles, so that E of one bunch is also A of the next.
- R3: With `dbl_mode_i` = 0 (unipolar), `phase_o` equals B − D as a 14-bit two's-complement value, exact for all 12-bit signed inputs, including full-scale extremes.
- R4: With `dbl_mode_i` = 0, `amp_o` equals C − floor((A+E)/2), where the halving is an arithmetic shift that rounds toward minus infinity for odd negative sums.
- R5: With `dbl_mode_i` = 1 (doublet), the roles swap: `amp_o` equals B − D and `phase_o` equals C − floor((A+E)/2).
- R6: The mode used for a bunch is the value of `dbl_mode_i` in the cycle carrying sample E. Mode changes during samples A to D have no effect on that bunch.
- R7: Each result adds `phase_o` to a batch sum. When the count of summed bunches reaches `batch_len_i`, `avg_o` gets the sum divided by `batch_len_i`, truncated toward zero, and `avg_vld_o` is 1 for that one cycle, the same cycle as that bunch's `meas_vld_o`. The next batch then starts empty by itself.
- R8: `batch_start_i` empties the batch sum and count. A bunch whose result is produced in the same cycle counts as the first bunch of the new batch.
- R9: Without a strobe four cycles earlier, `meas_vld_o` stays 0, and the held `phase_o`/`amp_o` values do not change, whatever samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four cycles per bunch period |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 12 | Signed filtered pickup sample |
| bnd_i | input | 1 | High in the cycle carrying sample A of a bunch |
| dbl_mode_i | input | 1 | 0 = unipolar pulse, 1 = bipolar doublet |
| batch_start_i | input | 1 | Empties the batch accumulator |
| batch_len_i | input | 8 | Number of bunches per batch average (1 to 255) |
| phase_o | output | 14 | Signed per-bunch phase |
| amp_o | output | 14 | Signed per-bunch amplitude or intensity |
| meas_vld_o | output | 1 | One-cycle pulse when a new per-bunch result is present |
| avg_o | output | 14 | Signed batch average of phase |
| avg_vld_o | output | 1 | One-cycle pulse when a new batch average is present |

## Verification
The properties assume that reset is low from time zero and that the sample, strobe and mode inputs are always known. The batch-average result is only meaningful when `batch_len_i` is at least 1 and changes only in a cycle where `batch_start_i` is also high. The stimulus keeps the batch length fixed within each batch and changes it only together with a start pulse that falls on a bunch-completion cycle. Samples span the full signed 12-bit range, and strobe spacings of both four and seven cycles are used, so both the overlapping-window case and the isolated-window case are covered.

// File: rtl/bunch_meas_pkg.sv
package bunch_meas_pkg;

    // Pickup type; selects which difference feeds which output
    typedef enum logic {
        PICKUP_UNIPOLAR = 1'b0,
        PICKUP_DOUBLET  = 1'b1
    } pickup_mode_e;

    // Samples per bunch window (A..E) and resulting history depth
    localparam int WIN_LEN  = 5;
    localparam int HIST_LEN = WIN_LEN - 1;

endpackage

// File: rtl/bunch_meas_window.sv
module bunch_meas_window
    import bunch_meas_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic                    bnd_i,
    output logic signed [SMP_W-1:0] a_o,
    output logic signed [SMP_W-1:0] b_o,
    output logic signed [SMP_W-1:0] c_o,
    output logic signed [SMP_W-1:0] d_o,
    output logic signed [SMP_W-1:0] e_o,
    output logic                    fire_o
);

    typedef struct packed {
        logic [HIST_LEN-1:0][SMP_W-1:0] hist;
        logic [HIST_LEN-1:0]            strb;
    } win_t;

    win_t win_q, win_d;

    always_comb begin
        win_d      = win_q;
        win_d.hist = {win_q.hist[HIST_LEN-2:0], smp_i};
        win_d.strb = {win_q.strb[HIST_LEN-2:0], bnd_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // When the strobe is HIST_LEN cycles old the live sample is E
    assign a_o    = $signed(win_q.hist[3]);
    assign b_o    = $signed(win_q.hist[2]);
    assign c_o    = $signed(win_q.hist[1]);
    assign d_o    = $signed(win_q.hist[0]);
    assign e_o    = smp_i;
    assign fire_o = win_q.strb[HIST_LEN-1];

endmodule

// File: rtl/bunch_meas_calc.sv
module bunch_meas_calc
    import bunch_meas_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int OUT_W = SMP_W + 2
) (
    input  logic signed [SMP_W-1:0] a_i,
    input  logic signed [SMP_W-1:0] b_i,
    input  logic signed [SMP_W-1:0] c_i,
    input  logic signed [SMP_W-1:0] d_i,
    input  logic signed [SMP_W-1:0] e_i,
    input  pickup_mode_e            mode_i,
    output logic signed [OUT_W-1:0] phase_o,
    output logic signed [OUT_W-1:0] amp_o
);

    logic signed [OUT_W-1:0] a_x, b_x, c_x, d_x, e_x;
    logic signed [OUT_W-1:0] outer_sum, outer_half;
    logic signed [OUT_W-1:0] diff_bd, diff_cm;

    always_comb begin
        a_x        = OUT_W'(a_i);
        b_x        = OUT_W'(b_i);
        c_x        = OUT_W'(c_i);
        d_x        = OUT_W'(d_i);
        e_x        = OUT_W'(e_i);
        outer_sum  = a_x + e_x;
        outer_half = outer_sum >>> 1;
        diff_bd    = b_x - d_x;
        diff_cm    = c_x - outer_half;
        if (mode_i == PICKUP_DOUBLET) begin
            phase_o = diff_cm;
            amp_o   = diff_bd;
        end else begin
            phase_o = diff_bd;
            amp_o   = diff_cm;
        end
    end

endmodule

// File: rtl/bunch_meas_batch.sv
module bunch_meas_batch #(
    parameter int OUT_W = 14,
    parameter int LEN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire_i,
    input  logic signed [OUT_W-1:0] phase_i,
    input  logic                    start_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic signed [OUT_W-1:0] avg_o,
    output logic                    avg_vld_o
);

    localparam int ACC_W = OUT_W + LEN_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [LEN_W-1:0]        cnt;
        logic signed [OUT_W-1:0] avg;
        logic                    vld;
    } bat_t;

    bat_t bat_q, bat_d;

    logic signed [ACC_W-1:0] acc_base, acc_sum, divisor, quot;
    logic [LEN_W-1:0]        cnt_base, cnt_next;

    always_comb begin
        bat_d    = bat_q;
        acc_base = start_i ? '0 : bat_q.acc;
        cnt_base = start_i ? '0 : bat_q.cnt;
        acc_sum  = acc_base + ACC_W'(phase_i);
        cnt_next = cnt_base + 1'b1;
        divisor  = $signed({{(ACC_W-LEN_W){1'b0}}, len_i});
        quot     = acc_sum / divisor;
        bat_d.vld = 1'b0;
        bat_d.acc = acc_base;
        bat_d.cnt = cnt_base;
        if (fire_i) begin
            if (cnt_next == len_i) begin
                bat_d.avg = quot[OUT_W-1:0];
                bat_d.vld = 1'b1;
                bat_d.acc = '0;
                bat_d.cnt = '0;
            end else begin
                bat_d.acc = acc_sum;
                bat_d.cnt = cnt_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bat_q <= '0;
        end else begin
            bat_q <= bat_d;
        end
    end

    assign avg_o     = bat_q.avg;
    assign avg_vld_o = bat_q.vld;

endmodule

// File: rtl/bunch_meas.sv
module bunch_meas
    import bunch_meas_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int LEN_W = 8,
    parameter int OUT_W = SMP_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic                    bnd_i,
    input  logic                    dbl_mode_i,
    input  logic                    batch_start_i,
    input  logic [LEN_W-1:0]        batch_len_i,
    output logic signed [OUT_W-1:0] phase_o,
    output logic signed [OUT_W-1:0] amp_o,
    output logic                    meas_vld_o,
    output logic signed [OUT_W-1:0] avg_o,
    output logic                    avg_vld_o
);

    logic signed [SMP_W-1:0] a_w, b_w, c_w, d_w, e_w;
    logic                    fire_w;
    logic signed [OUT_W-1:0] ph_c, am_c;
    pickup_mode_e            mode_c;

    assign mode_c = pickup_mode_e'(dbl_mode_i);

    bunch_meas_window #(.SMP_W(SMP_W)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp_i),
        .bnd_i  (bnd_i),
        .a_o    (a_w),
        .b_o    (b_w),
        .c_o    (c_w),
        .d_o    (d_w),
        .e_o    (e_w),
        .fire_o (fire_w)
    );

    bunch_meas_calc #(.SMP_W(SMP_W), .OUT_W(OUT_W)) calc_i (
        .a_i     (a_w),
        .b_i     (b_w),
        .c_i     (c_w),
        .d_i     (d_w),
        .e_i     (e_w),
        .mode_i  (mode_c),
        .phase_o (ph_c),
        .amp_o   (am_c)
    );

    bunch_meas_batch #(.OUT_W(OUT_W), .LEN_W(LEN_W)) bat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire_w),
        .phase_i   (ph_c),
        .start_i   (batch_start_i),
        .len_i     (batch_len_i),
        .avg_o     (avg_o),
        .avg_vld_o (avg_vld_o)
    );

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] ph;
        logic signed [OUT_W-1:0] am;
    } res_t;

    res_t res_q, res_d;

    always_comb begin
        res_d     = res_q;
        res_d.vld = fire_w;
        if (fire_w) begin
            res_d.ph = ph_c;
            res_d.am = am_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign phase_o    = res_q.ph;
    assign amp_o      = res_q.am;
    assign meas_vld_o = res_q.vld;

endmodule

// File: rtl/bunch_meas_chk.sv
module bunch_meas_chk #(
    parameter int SMP_W = 12,
    parameter int OUT_W = SMP_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [SMP_W-1:0] smp_i,
    input logic                    bnd_i,
    input logic                    dbl_mode_i,
    input logic signed [OUT_W-1:0] phase_o,
    input logic signed [OUT_W-1:0] amp_o,
    input logic                    meas_vld_o,
    input logic                    avg_vld_o
);

    logic signed [OUT_W-1:0] smp_x;
    assign smp_x = OUT_W'(smp_i);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!meas_vld_o && !avg_vld_o));

    // R2
    strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld_o |-> $past(bnd_i, 5));

    // R3
    uni_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld_o && !$past(dbl_mode_i)) |->
            (phase_o == $past(smp_x, 4) - $past(smp_x, 2)));

    // R4
    uni_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld_o && !$past(dbl_mode_i)) |->
            (amp_o == $past(smp_x, 3) - (($past(smp_x, 5) + $past(smp_x, 1)) >>> 1)));

    // R5
    dbl_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld_o && $past(dbl_mode_i)) |->
            (amp_o == $past(smp_x, 4) - $past(smp_x, 2)));

    // R7
    avg_with_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_o |-> meas_vld_o);

endmodule

bind bunch_meas bunch_meas_chk #(.SMP_W(SMP_W), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_i      (smp_i),
    .bnd_i      (bnd_i),
    .dbl_mode_i (dbl_mode_i),
    .phase_o    (phase_o),
    .amp_o      (amp_o),
    .meas_vld_o (meas_vld_o),
    .avg_vld_o  (avg_vld_o)
);

// File: tb/bunch_meas_tb_top.sv
module bunch_meas_tb_top;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] smp_i = '0;
    logic               bnd_i = 1'b0;
    logic               dbl_mode_i = 1'b0;
    logic               batch_start_i = 1'b0;
    logic [7:0]         batch_len_i = 8'd84;
    logic signed [13:0] phase_o, amp_o, avg_o;
    logic               meas_vld_o, avg_vld_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bunch_meas dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_i         (smp_i),
        .bnd_i         (bnd_i),
        .dbl_mode_i    (dbl_mode_i),
        .batch_start_i (batch_start_i),
        .batch_len_i   (batch_len_i),
        .phase_o       (phase_o),
        .amp_o         (amp_o),
        .meas_vld_o    (meas_vld_o),
        .avg_o         (avg_o),
        .avg_vld_o     (avg_vld_o)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: input history and expected outputs
    int sq[$];
    bit bq[$];
    bit mq[$];
    int  e_ph = 0, e_am = 0, e_avg = 0;
    bit  e_vld = 0, e_avgv = 0, e_mode = 0;
    int  acc = 0, cnt = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit fire_next();
        int t = sq.size();
        return (t >= 4) && bq[t-4];
    endfunction

    task automatic compare_outputs();
        check("R2", "meas_vld_o", int'(meas_vld_o), int'(e_vld));
        if (e_vld) begin
            check(e_mode ? "R5" : "R3", "phase_o", int'(phase_o), e_ph);
            check(e_mode ? "R5" : "R4", "amp_o", int'(amp_o), e_am);
        end else begin
            // R9: held values untouched
            check("R9", "phase_o held", int'(phase_o), e_ph);
            check("R9", "amp_o held", int'(amp_o), e_am);
        end
        check("R7", "avg_vld_o", int'(avg_vld_o), int'(e_avgv));
        if (e_avgv) check("R7", "avg_o", int'(avg_o), e_avg);
    endtask

    task automatic tick(input int s, input bit b, input bit m, input bit bs, input int len);
        int t, av, bv, cv, dv, ev, bd, cm;
        bit fire;
        @(negedge clk);
        compare_outputs();
        smp_i = 12'(s);
        bnd_i = b;
        dbl_mode_i = m;
        batch_start_i = bs;
        batch_len_i = 8'(len);
        sq.push_back(s);
        bq.push_back(b);
        mq.push_back(m);
        t = sq.size() - 1;
        fire = (t >= 4) && bq[t-4];
        e_vld = fire;
        e_avgv = 0;
        if (bs) begin
            acc = 0;
            cnt = 0;
        end
        if (fire) begin
            av = sq[t-4]; bv = sq[t-3]; cv = sq[t-2]; dv = sq[t-1]; ev = sq[t];
            bd = bv - dv;
            cm = cv - ((av + ev) >>> 1);
            e_mode = m;
            e_ph = m ? cm : bd;
            e_am = m ? bd : cm;
            acc += e_ph;
            cnt++;
            if (cnt == len) begin
                e_avg = acc / len;
                e_avgv = 1;
                acc = 0;
                cnt = 0;
            end
        end
    endtask

    function automatic int rnd12();
        logic signed [11:0] v = 12'($urandom);
        return int'(v);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s;
        bit armed;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "meas_vld_o in reset", int'(meas_vld_o), 0);
        check("R1", "avg_vld_o in reset", int'(avg_vld_o), 0);
        check("R1", "phase_o in reset", int'(phase_o), 0);
        check("R1", "amp_o in reset", int'(amp_o), 0);
        check("R1", "avg_o in reset", int'(avg_o), 0);
        rst_n = 1'b1;

        // R3 R4: unipolar, full-scale extremes first, back-to-back windows
        for (int i = 0; i < 120; i++) begin
            case (i)
                0: s = -2048;
                1: s = 2047;
                2: s = 2047;
                3: s = -2048;
                4: s = -2047;
                default: s = rnd12();
            endcase
            tick(s, (i % 4) == 0, 1'b0, i == 0, 84);
        end
        // R5: doublet mode
        for (int i = 0; i < 120; i++) tick(rnd12(), (i % 4) == 0, 1'b1, 1'b0, 84);
        // R6: mode changes every cycle, only the E-cycle value matters
        for (int i = 0; i < 40; i++) tick(rnd12(), (i % 4) == 0, 1'($urandom), 1'b0, 84);
        // R9: isolated windows, gaps of three cycles between bunches
        for (int i = 0; i < 70; i++) tick(rnd12(), (i % 7) == 0, 1'($urandom), 1'b0, 84);
        // R7: finish the 84-bunch batch
        for (int i = 0; i < 80; i++) tick(rnd12(), (i % 4) == 0, 1'b0, 1'b0, 84);
        // R8: restart with length 3 exactly on a completion cycle
        armed = 1'b1;
        for (int i = 0; i < 80; i++) begin
            bit go = armed && fire_next();
            if (go) armed = 1'b0;
            tick(rnd12(), (i % 4) == 0, 1'(i / 40), go, armed ? 84 : 3);
        end
        // R7: length 1 gives one average per bunch
        for (int i = 0; i < 24; i++) tick(rnd12(), (i % 4) == 0, 1'b0, i == 0, 1);
        for (int i = 0; i < 6; i++) tick(0, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        compare_outputs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule